// File: doc/BRIEF.md
# Microcoded Dual Receive/Transmit FIFO Controller

This block runs two independent byte FIFOs, one for the receive path and one for the transmit path of a serial port. Both FIFOs keep their data in one synchronous RAM. A FIFO-select bit is the top address bit, so each FIFO has its own half of the RAM. Each FIFO has a read pointer, a write pointer and an occupancy count. These six values sit in a small register file with a single port rather than in dedicated counters, and one shared adder updates all of them.

A microprogram ROM inside the block steps a small sequencer through every operation. For each step the ROM supplies the register-file selector, the adder function, the RAM strobes and the next-address rule. Users raise a level request and keep it, and the push data with it, until the matching acknowledge pulse. After reset a microcoded walk clears the register file, and `ready` stays low until that walk is done.

Top module: `mcfifo_dual`

## Requirements
- R1: While `rst` is high, `ready` is low and both FIFOs report empty=1, full=0. After `rst` falls, the init walk clears all 8 register-file words, and `ready` goes high after exactly 8 rising clock edges. Once high, `ready` stays high until the next reset.
- R2: Within each FIFO, words come out in the order they were pushed, with the values they had when pushed.
- R3: The two FIFOs are independent. The RAM address is {fifo bit, pointer[3:0]}, with receive = 0 and transmit = 1. Pushing or popping one FIFO never changes the data, count or flags of the other.
- R4: A push to a full FIFO (16 words) is acknowledged but has no other effect. The count, the pointers and the stored data all stay as they were.
- R5: A pop from an empty FIFO is acknowledged but has no other effect. The pop data output and the flags keep their previous values.
- R6: The empty flag is 1 exactly when the count is 0, and the full flag is 1 exactly when the count is 16. Both flags change only on the clock edge that ends the acknowledge cycle of a performed operation, and never at the same time as each other.
- R7: When requests are pending together, they are served one at a time in this fixed order: receive push, receive pop, transmit push, transmit pop.
- R8: If a request is present while the block is idle, a performed operation asserts its acknowledge for one cycle after the 4th rising edge. An ignored operation does so after the 1st rising edge. The sequencer then returns to idle.
- R9: Each FIFO's pop data output changes only on a performed pop of that FIFO. When that pop is acknowledged, the output already holds the popped word.
- R10: Pointers wrap modulo 16 and never carry into the FIFO-select bit, so the FIFOs keep working correctly over any number of operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | High once the init walk has finished |
| rx_push_req | input | 1 | Receive push request, held until acknowledged |
| rx_push_data | input | 8 | Word to push into the receive FIFO |
| rx_push_ack | output | 1 | Receive push acknowledge pulse |
| rx_pop_req | input | 1 | Receive pop request, held until acknowledged |
| rx_pop_ack | output | 1 | Receive pop acknowledge pulse |
| rx_pop_data | output | 8 | Last word popped from the receive FIFO |
| rx_empty | output | 1 | Receive FIFO holds no words |
| rx_full | output | 1 | Receive FIFO holds 16 words |
| tx_push_req | input | 1 | Transmit push request, held until acknowledged |
| tx_push_data | input | 8 | Word to push into the transmit FIFO |
| tx_push_ack | output | 1 | Transmit push acknowledge pulse |
| tx_pop_req | input | 1 | Transmit pop request, held until acknowledged |
| tx_pop_ack | output | 1 | Transmit pop acknowledge pulse |
| tx_pop_data | output | 8 | Last word popped from the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO holds no words |
| tx_full | output | 1 | Transmit FIFO holds 16 words |

## Verification
The bench fills the receive FIFO to exactly 16 words and then pushes once more. If the full test were off by one, the extra word would overwrite the oldest entry and the drain would return the wrong sequence. It pops the empty FIFO both straight after reset and after a drain. A design that accepts such a pop would move its read pointer, change the pop data output or send the count negative, and all three are visible on later operations.

It raises all four requests in the same cycle and records the order of the acknowledges, which exposes a wrong priority or a lost request. Long random runs push the pointers through many wraps. If a pointer carried into the FIFO-select bit, data would cross between the two FIFOs and show up as wrong words on the other side.

// File: rtl/mcfifo_pkg.sv
package mcfifo_pkg;

    localparam int NFIFO  = 2;
    localparam int FSEL_W = 1;
    localparam int NREQ   = 2 * NFIFO;
    localparam int RF_AW  = FSEL_W + 2;
    localparam int UPC_W  = 4;
    localparam int UROM_DEPTH = 2 ** UPC_W;

    typedef enum logic [1:0] {RS_CNT = 2'd0, RS_RP = 2'd1, RS_WP = 2'd2, RS_SPARE = 2'd3} rsel_e;
    typedef enum logic [1:0] {AD_ZERO, AD_INC, AD_DEC, AD_PASS} addop_e;
    typedef enum logic [1:0] {NX_NEXT, NX_IDLE, NX_DISPATCH, NX_WALK} nxt_e;
    typedef enum logic [1:0] {OP_RXPUSH = 2'd0, OP_RXPOP = 2'd1, OP_TXPUSH = 2'd2, OP_TXPOP = 2'd3} opcode_e;

    typedef enum logic [UPC_W-1:0] {
        UA_INIT = 4'd0, UA_IDLE = 4'd1, UA_NACK = 4'd2,
        UA_PSH0 = 4'd3, UA_PSH1 = 4'd4, UA_PSH2 = 4'd5, UA_PSH3 = 4'd6,
        UA_POP0 = 4'd7, UA_POP1 = 4'd8, UA_POP2 = 4'd9, UA_POP3 = 4'd10
    } uaddr_e;

    typedef struct packed {
        rsel_e  rsel;
        logic   walk;
        logic   ld_opnd;
        logic   rf_we;
        addop_e aop;
        logic   ram_we;
        logic   ram_re;
        logic   flag_upd;
        logic   ack;
        nxt_e   nxt;
    } uinstr_t;

    function automatic logic op_is_push(opcode_e o);
        return ~o[0];
    endfunction

    function automatic logic op_fifo(opcode_e o);
        return o[1];
    endfunction

    // Microprogram contents, one word per microaddress.
    function automatic uinstr_t ucode(input logic [UPC_W-1:0] a);
        uinstr_t u;
        u = '0;
        u.nxt = NX_IDLE;
        case (a)
            UA_INIT: begin u.walk = 1'b1; u.rf_we = 1'b1; u.aop = AD_ZERO; u.nxt = NX_WALK; end
            UA_IDLE: begin u.nxt = NX_DISPATCH; end
            UA_NACK: begin u.ack = 1'b1; u.nxt = NX_IDLE; end
            UA_PSH0: begin u.rsel = RS_WP; u.ld_opnd = 1'b1; u.nxt = NX_NEXT; end
            UA_PSH1: begin u.rsel = RS_WP; u.rf_we = 1'b1; u.aop = AD_INC; u.ram_we = 1'b1; u.nxt = NX_NEXT; end
            UA_PSH2: begin u.rsel = RS_CNT; u.ld_opnd = 1'b1; u.nxt = NX_NEXT; end
            UA_PSH3: begin u.rsel = RS_CNT; u.rf_we = 1'b1; u.aop = AD_INC; u.flag_upd = 1'b1; u.ack = 1'b1; u.nxt = NX_IDLE; end
            UA_POP0: begin u.rsel = RS_RP; u.ld_opnd = 1'b1; u.nxt = NX_NEXT; end
            UA_POP1: begin u.rsel = RS_RP; u.rf_we = 1'b1; u.aop = AD_INC; u.ram_re = 1'b1; u.nxt = NX_NEXT; end
            UA_POP2: begin u.rsel = RS_CNT; u.ld_opnd = 1'b1; u.nxt = NX_NEXT; end
            UA_POP3: begin u.rsel = RS_CNT; u.rf_we = 1'b1; u.aop = AD_DEC; u.flag_upd = 1'b1; u.ack = 1'b1; u.nxt = NX_IDLE; end
            default: begin u.nxt = NX_IDLE; end
        endcase
        return u;
    endfunction

endpackage

// File: rtl/mcfifo_regfile.sv
module mcfifo_regfile #(
    parameter int DW = 5,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/mcfifo_bram.sv
module mcfifo_bram #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/mcfifo_useq.sv
module mcfifo_useq
    import mcfifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NREQ-1:0]     req,
    input  logic [NFIFO-1:0]    full,
    input  logic [NFIFO-1:0]    empty,
    output uinstr_t             ui,
    output opcode_e             cur_op,
    output logic [RF_AW-1:0]    walk_idx,
    output logic                ready
);
    uaddr_e  upc, upc_nx;
    opcode_e op_nx;
    logic    hit;
    uinstr_t rom [UROM_DEPTH];

    for (genvar gi = 0; gi < UROM_DEPTH; gi++) begin : g_rom
        assign rom[gi] = ucode(UPC_W'(gi));
    end

    assign ui = rom[upc];

    always_comb begin
        op_nx = OP_RXPUSH;
        hit   = 1'b0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            if (req[k]) begin
                op_nx = opcode_e'(2'(k));
                hit   = 1'b1;
            end
        end
        upc_nx = UA_IDLE;
        case (ui.nxt)
            NX_NEXT:     upc_nx = uaddr_e'(upc + 4'd1);
            NX_IDLE:     upc_nx = UA_IDLE;
            NX_WALK:     upc_nx = (walk_idx == '1) ? UA_IDLE : UA_INIT;
            NX_DISPATCH: begin
                if (hit) begin
                    if (op_is_push(op_nx))
                        upc_nx = full[op_fifo(op_nx)] ? UA_NACK : UA_PSH0;
                    else
                        upc_nx = empty[op_fifo(op_nx)] ? UA_NACK : UA_POP0;
                end
            end
            default:     upc_nx = UA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc      <= UA_INIT;
            walk_idx <= '0;
            cur_op   <= OP_RXPUSH;
        end else begin
            upc <= upc_nx;
            if (ui.walk) walk_idx <= walk_idx + 1'b1;
            if (ui.nxt == NX_DISPATCH && hit) cur_op <= op_nx;
        end
    end

    assign ready = (upc != UA_INIT);

    assert_ready_holds_R1: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_ack_then_idle_R8: assert property (@(posedge clk) disable iff (rst)
        ui.ack |=> (upc == UA_IDLE));

    assert_rx_push_first_R7: assert property (@(posedge clk) disable iff (rst)
        (upc == UA_IDLE && req[0]) |=> (cur_op == OP_RXPUSH));
endmodule

// File: rtl/mcfifo_dual.sv
module mcfifo_dual
    import mcfifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ready,
    input  logic              rx_push_req,
    input  logic [DATA_W-1:0] rx_push_data,
    output logic              rx_push_ack,
    input  logic              rx_pop_req,
    output logic              rx_pop_ack,
    output logic [DATA_W-1:0] rx_pop_data,
    output logic              rx_empty,
    output logic              rx_full,
    input  logic              tx_push_req,
    input  logic [DATA_W-1:0] tx_push_data,
    output logic              tx_push_ack,
    input  logic              tx_pop_req,
    output logic              tx_pop_ack,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic              tx_empty,
    output logic              tx_full
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int CNT_W  = PTR_W + 1;
    localparam int RAM_AW = FSEL_W + PTR_W;

    uinstr_t             ui;
    opcode_e             cur_op;
    logic [RF_AW-1:0]    walk_idx;
    logic                cur_fifo;
    logic [NREQ-1:0]     req, ack;
    logic [RF_AW-1:0]    rf_addr;
    logic [CNT_W-1:0]    rf_rdata, rf_wdata, opnd, sum;
    logic [RAM_AW-1:0]   ram_addr;
    logic [DATA_W-1:0]   ram_wdata, ram_q;
    logic                rd_strobe_d;
    logic [NFIFO-1:0]    empty_q, full_q;
    logic [NFIFO-1:0][DATA_W-1:0] pop_q, push_d;

    assign req    = {tx_pop_req, tx_push_req, rx_pop_req, rx_push_req};
    assign push_d = {tx_push_data, rx_push_data};

    mcfifo_useq u_useq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .full     (full_q),
        .empty    (empty_q),
        .ui       (ui),
        .cur_op   (cur_op),
        .walk_idx (walk_idx),
        .ready    (ready)
    );

    assign cur_fifo = op_fifo(cur_op);
    assign rf_addr  = ui.walk ? walk_idx : {cur_fifo, ui.rsel};

    mcfifo_regfile #(.DW(CNT_W), .AW(RF_AW)) u_rf (
        .clk   (clk),
        .we    (ui.rf_we),
        .addr  (rf_addr),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    // Operand latch and shared adder.
    always_ff @(posedge clk) begin
        if (rst)             opnd <= '0;
        else if (ui.ld_opnd) opnd <= rf_rdata;
    end

    always_comb begin
        case (ui.aop)
            AD_INC:  sum = opnd + 1'b1;
            AD_DEC:  sum = opnd - 1'b1;
            AD_PASS: sum = opnd;
            default: sum = '0;
        endcase
    end

    // Pointers keep only PTR_W bits so they wrap at DEPTH.
    assign rf_wdata = (ui.rsel == RS_CNT) ? sum : {1'b0, sum[PTR_W-1:0]};

    assign ram_addr  = {cur_fifo, opnd[PTR_W-1:0]};
    assign ram_wdata = push_d[cur_fifo];

    mcfifo_bram #(.DW(DATA_W), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ui.ram_we),
        .re    (ui.ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    // Output load strobe trails the RAM read by one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_strobe_d <= 1'b0;
            pop_q       <= '0;
            empty_q     <= '1;
            full_q      <= '0;
        end else begin
            rd_strobe_d <= ui.ram_re;
            if (rd_strobe_d) pop_q[cur_fifo] <= ram_q;
            if (ui.flag_upd) begin
                empty_q[cur_fifo] <= (sum == '0);
                full_q[cur_fifo]  <= (sum == CNT_W'(DEPTH));
            end
        end
    end

    for (genvar gk = 0; gk < NREQ; gk++) begin : g_ack
        assign ack[gk] = ui.ack && (cur_op == opcode_e'(2'(gk)));
    end

    assign rx_push_ack = ack[0];
    assign rx_pop_ack  = ack[1];
    assign tx_push_ack = ack[2];
    assign tx_pop_ack  = ack[3];
    assign rx_pop_data = pop_q[0];
    assign tx_pop_data = pop_q[1];
    assign rx_empty    = empty_q[0];
    assign rx_full     = full_q[0];
    assign tx_empty    = empty_q[1];
    assign tx_full     = full_q[1];

    assert_no_write_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        ui.ram_we |-> !full_q[cur_fifo]);

    assert_no_read_when_empty_R5: assert property (@(posedge clk) disable iff (rst)
        ui.ram_re |-> !empty_q[cur_fifo]);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        ((empty_q & full_q) == '0));

    assert_flags_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !ui.flag_upd |=> ($stable(empty_q) && $stable(full_q)));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (ui.rf_we && !ui.walk && ui.rsel == RS_CNT) |-> (rf_wdata <= CNT_W'(DEPTH)));

    assert_pop_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe_d |=> $stable(pop_q));
endmodule

// File: tb/tb_mcfifo_dual.sv
module tb_mcfifo_dual;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ready;
    logic [3:0] reqs = '0;
    logic [7:0] rx_d = '0, tx_d = '0;
    logic rx_push_ack, rx_pop_ack, tx_push_ack, tx_pop_ack;
    logic [7:0] rx_pop_data, tx_pop_data;
    logic rx_empty, rx_full, tx_empty, tx_full;

    always #5 clk = ~clk;

    mcfifo_dual dut (
        .clk(clk), .rst(rst), .ready(ready),
        .rx_push_req(reqs[0]), .rx_push_data(rx_d), .rx_push_ack(rx_push_ack),
        .rx_pop_req(reqs[1]), .rx_pop_ack(rx_pop_ack), .rx_pop_data(rx_pop_data),
        .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_push_req(reqs[2]), .tx_push_data(tx_d), .tx_push_ack(tx_push_ack),
        .tx_pop_req(reqs[3]), .tx_pop_ack(tx_pop_ack), .tx_pop_data(tx_pop_data),
        .tx_empty(tx_empty), .tx_full(tx_full)
    );

    int nchk = 0, nfail = 0;
    logic [7:0] mq [2][16];
    int mhead [2];
    int mcnt [2];
    logic [7:0] last_pop [2];

    function automatic logic [3:0] acks();
        return {tx_pop_ack, tx_push_ack, rx_pop_ack, rx_push_ack};
    endfunction

    function automatic logic [7:0] popd(int f);
        return (f == 0) ? rx_pop_data : tx_pop_data;
    endfunction

    function automatic logic [1:0] flags(int f);
        return (f == 0) ? {rx_full, rx_empty} : {tx_full, tx_empty};
    endfunction

    function automatic logic [1:0] exp_flags(int f);
        return {mcnt[f] == 16, mcnt[f] == 0};
    endfunction

    task automatic check(bit ok, string rq, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic void model_apply(int op, logic [7:0] d);
        int f;
        f = op >> 1;
        if ((op & 1) == 0) begin
            if (mcnt[f] < 16) begin
                mq[f][(mhead[f] + mcnt[f]) % 16] = d;
                mcnt[f]++;
            end
        end else if (mcnt[f] > 0) begin
            last_pop[f] = mq[f][mhead[f]];
            mhead[f] = (mhead[f] + 1) % 16;
            mcnt[f]--;
        end
    endfunction

    // One request, held until its acknowledge; called at a negedge.
    task automatic do_op(int op, logic [7:0] d);
        int f, lat, exp_lat;
        bit push, ign;
        logic [7:0] exp_pop;
        f = op >> 1;
        push = ((op & 1) == 0);
        ign = push ? (mcnt[f] == 16) : (mcnt[f] == 0);
        exp_lat = ign ? 1 : 4;
        if (f == 0) rx_d = d; else tx_d = d;
        reqs[op] = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!acks()[op] && lat < 40);
        reqs[op] = 1'b0;
        check(acks()[op] === 1'b1 && lat == exp_lat, "R8 ack latency", lat, exp_lat);
        model_apply(op, d);
        exp_pop = last_pop[f];
        if (!push && !ign)
            check(popd(f) === exp_pop, "R2 pop order/value", popd(f), exp_pop);
        else
            check(popd(f) === exp_pop, ign && !push ? "R5 empty pop leaves data" : "R9 pop data hold",
                  popd(f), exp_pop);
        check(popd(1 - f) === last_pop[1 - f], "R3 other fifo data", popd(1 - f), last_pop[1 - f]);
        @(negedge clk);
        check(flags(f) === exp_flags(f), ign ? (push ? "R4 full push flags" : "R5 empty pop flags") : "R6 flags",
              flags(f), exp_flags(f));
        check(flags(1 - f) === exp_flags(1 - f), "R3 other fifo flags", flags(1 - f), exp_flags(1 - f));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        int cyc;
        logic [3:0] order [4];
        int nacks;
        void'($urandom(32'h1C55_0A07));
        for (int f = 0; f < 2; f++) begin mhead[f] = 0; mcnt[f] = 0; last_pop[f] = '0; end

        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready === 1'b0, "R1 ready low in reset", ready, 0);
        check({rx_full, rx_empty, tx_full, tx_empty} === 4'b0101, "R1 flags in reset",
              {rx_full, rx_empty, tx_full, tx_empty}, 4'b0101);
        rst = 1'b0;
        cyc = 0;
        while (!ready && cyc < 40) begin @(negedge clk); cyc++; end
        check(cyc == 8, "R1 init walk length", cyc, 8);

        // R5: pop from empty right after reset
        do_op(1, 8'h00);
        do_op(3, 8'h00);

        // R3/R4: fill receive to full, then overflow attempts
        for (int i = 0; i < 16; i++) do_op(0, 8'(8'hA0 + i));
        check(rx_full === 1'b1, "R6 full at 16", rx_full, 1);
        do_op(0, 8'h55);
        do_op(0, 8'h66);
        check(tx_empty === 1'b1, "R3 tx untouched", tx_empty, 1);
        for (int i = 0; i < 3; i++) do_op(2, 8'(8'h30 + i));
        for (int i = 0; i < 16; i++) do_op(1, 8'h00);
        check(rx_pop_data === 8'hAF, "R4 last word not overwritten", rx_pop_data, 8'hAF);
        do_op(1, 8'h00);

        // R7: all four requests at once
        do_op(0, 8'h11);
        rx_d = 8'h77;
        tx_d = 8'h88;
        reqs = 4'b1111;
        nacks = 0;
        cyc = 0;
        while (nacks < 4 && cyc < 100) begin
            @(negedge clk);
            cyc++;
            for (int k = 0; k < 4; k++) begin
                if (acks()[k]) begin
                    order[nacks] = 4'(k);
                    nacks++;
                    reqs[k] = 1'b0;
                    model_apply(k, (k < 2) ? 8'h77 : 8'h88);
                end
            end
        end
        @(negedge clk);
        for (int k = 0; k < 4; k++)
            check(nacks == 4 && order[k] == 4'(k), "R7 service order", order[k], k);
        check(rx_pop_data === last_pop[0], "R7 rx pop value", rx_pop_data, last_pop[0]);
        check(tx_pop_data === last_pop[1], "R7 tx pop value", tx_pop_data, last_pop[1]);

        // R10/R2: random traffic with phases biased toward filling and draining
        for (int ph = 0; ph < 8; ph++) begin
            for (int i = 0; i < 90; i++) begin
                int op;
                op = int'($urandom_range(0, 3));
                if ((ph % 2) == 0 && ($urandom_range(0, 3) != 0)) op = op & 2;
                if ((ph % 2) == 1 && ($urandom_range(0, 3) != 0)) op = op | 1;
                do_op(op, 8'($urandom));
            end
        end

        // Drain both to confirm order after many wraps (R10)
        for (int i = 0; i < 17; i++) do_op(1, 8'h00);
        for (int i = 0; i < 17; i++) do_op(3, 8'h00);
        check(rx_empty === 1'b1 && tx_empty === 1'b1, "R10 drained after wraps",
              {rx_empty, tx_empty}, 2'b11);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule